// File: doc/BRIEF.md
# Light-Load Phase Shedding Controller

This block decides which PWM phases of a multiphase voltage regulator run. When the processor pulls the active-low power-saving flag low, it sheds one or two phases, always from the highest-numbered phase down. The choice between shedding none, one or two phases comes from a strap code. That code is captured once, at the point where soft-start finishes and power-good first rises, and it is not re-read after that. When the flag returns high, every configured phase comes back. A phase change only takes effect at a PWM period boundary, and a one-cycle pulse marks each change.

For each active phase count the block produces four things. The first is a per-phase enable mask, where a cleared bit puts that PWM output in high impedance. The second is the interleave step in degrees, equal to 360 divided by the active count. The third is the active count itself, which feeds current sharing. The fourth is the value for the open-drain flag pin. That pin value is the flag ANDed with the driver-enable signal, so the pin reads low whenever the drivers are held off.

Top module: `phase_shed_ctrl`

## Requirements
- R1: After synchronous active-low reset, every configured phase is enabled, the change pulse is low and no strategy is held.
- R2: The strap is captured on the first clock where `pgood` and `ss_done` are both high. Code 0 means keep all phases, code 1 means drop one, code 2 means drop two, and code 3 is treated as 0. Later strap changes have no effect.
- R3: Until the strategy is captured, all configured phases stay enabled whatever the flag level.
- R4: With the strategy captured and `psave_n` low, phases are removed from the highest index down. Bit i of `phase_en` is 1 exactly when i is less than the active count.
- R5: Only a 3-phase configuration may drop to 1 phase. All other configurations never go below 2 phases, so a 1-phase or 2-phase configuration never changes.
- R6: When `psave_n` is high, the next period boundary restores all configured phases.
- R7: The shed amount is updated only on a clock where `pwm_sync` is high, and the new value appears on the outputs in the following cycle.
- R8: `active_cnt` equals the number of enabled phases, and `shift_deg` equals 360 / `active_cnt` (360, 180, 120, 90).
- R9: `flag_pin` equals `psave_n` AND `drv_en`.
- R10: `cfg_change` is high for exactly one cycle, in the same cycle that a new phase configuration first appears.
- R11: A configured count of 0 is treated as 1, and a count above 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psave_n | input | 1 | Power-saving flag, active low |
| cfg_phases | input | 3 | Configured phase count strap |
| strap_code | input | 2 | Shedding strategy strap |
| pgood | input | 1 | Power-good |
| ss_done | input | 1 | Soft-start complete |
| drv_en | input | 1 | External driver enable |
| pwm_sync | input | 1 | PWM period-start pulse |
| phase_en | output | 4 | Per-phase enable, 0 = high impedance |
| active_cnt | output | 3 | Active phase count for current sharing |
| shift_deg | output | 9 | Interleave step in degrees |
| flag_pin | output | 1 | Open-drain flag pin value |
| cfg_change | output | 1 | One-cycle pulse on phase configuration change |

## Verification
Each fault in the internal state shows up at the outputs within a known time:
- A wrong captured strategy gives a wrong mask and count in the cycle after the first period boundary that falls during a flag-low window.
- A shed register that moves off a boundary shows up as a mask change in a cycle where `pwm_sync` was low the cycle before.
- A missing restore leaves high-numbered bits cleared one cycle after a boundary with the flag high.

The bench uses a behavioural reference model and compares all five outputs every cycle. It runs each strap code against each configured count, including the out-of-range counts. It also changes the strap after capture and drops the driver enable part-way through a run.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic [1:0] {
        STRAT_KEEP  = 2'd0,
        STRAT_DROP1 = 2'd1,
        STRAT_DROP2 = 2'd2,
        STRAT_RSVD  = 2'd3
    } strat_e;
endpackage

// File: rtl/psc_strategy_latch.sv
module psc_strategy_latch
    import psc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pgood,
    input  logic       ss_done,
    input  logic [1:0] strap,
    output logic       latched,
    output strat_e     strat
);
    typedef struct packed {
        logic   latched;
        strat_e strat;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.latched && pgood && ss_done) begin
            st_d.latched = 1'b1;
            st_d.strat   = (strap == STRAT_RSVD) ? STRAT_KEEP : strat_e'(strap);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{latched: 1'b0, strat: STRAT_KEEP};
        else        st_q <= st_d;
    end

    assign latched = st_q.latched;
    assign strat   = st_q.strat;

    // R2
    strat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.latched |=> (st_q.latched && $stable(st_q.strat)));
endmodule

// File: rtl/psc_shed_plan.sv
module psc_shed_plan
    import psc_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [CW-1:0] cfg,
    input  logic          latched,
    input  strat_e        strat,
    input  logic          psave_n,
    output logic [CW-1:0] shed_tgt
);
    logic [CW-1:0] drop, flr, avail;

    always_comb begin
        case (strat)
            STRAT_DROP1: drop = CW'(1);
            STRAT_DROP2: drop = CW'(2);
            default:     drop = CW'(0);
        endcase
        flr   = (cfg == CW'(3)) ? CW'(1) : CW'(2);
        avail = (cfg > flr) ? cfg - flr : CW'(0);
        if (!latched || psave_n) shed_tgt = CW'(0);
        else                     shed_tgt = (drop < avail) ? drop : avail;
    end
endmodule

// File: rtl/phase_shed_ctrl.sv
module phase_shed_ctrl
    import psc_pkg::*;
#(
    parameter int NPH = 4,
    parameter int CW  = $clog2(NPH + 1),
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psave_n,
    input  logic [CW-1:0] cfg_phases,
    input  logic [1:0]    strap_code,
    input  logic          pgood,
    input  logic          ss_done,
    input  logic          drv_en,
    input  logic          pwm_sync,
    output logic [NPH-1:0] phase_en,
    output logic [CW-1:0] active_cnt,
    output logic [DW-1:0] shift_deg,
    output logic          flag_pin,
    output logic          cfg_change
);
    localparam int FULL_TURN = 360;

    typedef struct packed {
        logic [CW-1:0] shed;
        logic          chg;
    } reg_t;

    reg_t          r_d, r_q;
    logic          latched;
    strat_e        strat;
    logic [CW-1:0] cfg_c, shed_tgt, active;
    logic [DW-1:0] step_tab [0:NPH];

    always_comb begin
        if (cfg_phases == '0)                cfg_c = CW'(1);
        else if (cfg_phases > CW'(NPH))      cfg_c = CW'(NPH);
        else                                 cfg_c = cfg_phases;
    end

    psc_strategy_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .pgood   (pgood),
        .ss_done (ss_done),
        .strap   (strap_code),
        .latched (latched),
        .strat   (strat)
    );

    psc_shed_plan #(.CW(CW)) u_plan (
        .cfg      (cfg_c),
        .latched  (latched),
        .strat    (strat),
        .psave_n  (psave_n),
        .shed_tgt (shed_tgt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.chg = 1'b0;
        if (pwm_sync) begin
            r_d.shed = shed_tgt;
            r_d.chg  = (shed_tgt != r_q.shed);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{shed: '0, chg: 1'b0};
        else        r_q <= r_d;
    end

    assign active = (cfg_c > r_q.shed) ? cfg_c - r_q.shed : CW'(1);

    for (genvar g = 0; g <= NPH; g++) begin : g_step
        if (g == 0) begin : g_zero
            assign step_tab[g] = DW'(FULL_TURN);
        end else begin : g_div
            assign step_tab[g] = DW'(FULL_TURN / g);
        end
    end

    for (genvar i = 0; i < NPH; i++) begin : g_mask
        assign phase_en[i] = (CW'(i) < active);
    end

    assign active_cnt = active;
    assign shift_deg  = step_tab[active];
    assign flag_pin   = psave_n & drv_en;
    assign cfg_change = r_q.chg;

    // R7
    shed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_sync |=> $stable(r_q.shed));
    // R6
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psave_n && pwm_sync) |=> (active_cnt == cfg_c));
    // R10
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |-> (r_q.shed != $past(r_q.shed)));
    // R5
    floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_c >= CW'(2) && cfg_c != CW'(3)) |-> (active_cnt >= CW'(2)));
endmodule

// File: tb/test_phase_shed_ctrl.sv
module test_phase_shed_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, psave_n, pgood, ss_done, drv_en, pwm_sync;
    logic [2:0] cfg_phases;
    logic [1:0] strap_code;
    logic [3:0] phase_en;
    logic [2:0] active_cnt;
    logic [8:0] shift_deg;
    logic       flag_pin, cfg_change;

    int tests = 0, fails = 0;
    int m_lat, m_strat, m_shed, m_chg;

    always #5 clk = ~clk;

    phase_shed_ctrl i_phase_shed_ctrl (
        .clk(clk), .rst_n(rst_n), .psave_n(psave_n), .cfg_phases(cfg_phases),
        .strap_code(strap_code), .pgood(pgood), .ss_done(ss_done),
        .drv_en(drv_en), .pwm_sync(pwm_sync), .phase_en(phase_en),
        .active_cnt(active_cnt), .shift_deg(shift_deg),
        .flag_pin(flag_pin), .cfg_change(cfg_change)
    );

    function automatic int clampc(int c);
        // R11: 0 reads as 1, above 4 reads as 4
        if (c == 0) return 1;
        if (c > 4) return 4;
        return c;
    endfunction

    function automatic int target(int c);
        int drop, flr, avail;
        if (m_lat == 0 || psave_n) return 0;
        drop  = (m_strat == 1) ? 1 : (m_strat == 2) ? 2 : 0;
        flr   = (c == 3) ? 1 : 2;        // R5
        avail = (c > flr) ? c - flr : 0;
        return (drop < avail) ? drop : avail;
    endfunction

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cfg=%0d strap=%0d t=%0t)",
                     tag, act, exp, cfg_phases, strap_code, $time);
        end
    endtask

    task automatic step();
        int c, t;
        @(posedge clk);
        c = clampc(cfg_phases);
        if (!rst_n) begin
            m_lat = 0; m_strat = 0; m_shed = 0; m_chg = 0;
        end else begin
            t = target(c);
            if (m_lat == 0 && pgood && ss_done) begin
                m_lat = 1;           // R2 capture, later straps ignored
                m_strat = (strap_code == 3) ? 0 : int'(strap_code);
            end
            if (pwm_sync) begin      // R7 only at period boundary
                m_chg  = (t != m_shed) ? 1 : 0;
                m_shed = t;
            end else m_chg = 0;
        end
        @(negedge clk);
        if (rst_n) begin
            int a;
            string tg;
            a  = c - m_shed;
            tg = (m_lat == 0) ? "R1 R3" : (psave_n ? "R6 R7" : "R2 R4 R5 R7 R11");
            check(tg, int'(phase_en), (1 << a) - 1);
            check("R8 count", int'(active_cnt), a);
            check("R8 step", int'(shift_deg), 360 / a);
            check("R9", int'(flag_pin), int'(psave_n & drv_en));
            check("R10", int'(cfg_change), m_chg);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 0; psave_n = 1; pgood = 0; ss_done = 0; drv_en = 0; pwm_sync = 0;
        cfg_phases = 3'd4; strap_code = 2'd0;
        for (int c = 0; c <= 5; c++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                rst_n = 0; cfg_phases = 3'(c); strap_code = 2'(s);
                psave_n = 0; pgood = 0; ss_done = 0; drv_en = 0; pwm_sync = 0;
                repeat (3) step();
                rst_n = 1;
                step();
                // R1 reset state seen at the ports
                check("R1 reset", int'(active_cnt), clampc(c));
                check("R1 pulse", int'(cfg_change), 0);
                for (int cyc = 0; cyc < 80; cyc++) begin
                    pwm_sync = (cyc % 4 == 3);
                    ss_done  = (cyc >= 10);
                    pgood    = (cyc >= 12);
                    drv_en   = (cyc >= 5) && !(cyc >= 60 && cyc < 64);
                    psave_n  = (cyc >= 30 && cyc < 45) || (cyc >= 70);
                    if (cyc == 50) strap_code = ~2'(s);
                    step();
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule